// File: doc/BRIEF.md
# Streaming Accelerator Wrapper with Register Control and Bus-Master Transfers

This block places a small fixed-function compute core behind a handful of host-visible registers and moves the core's data between memory and the core without the host's help. The host programs a source address, a destination address and a word count, then sets a start bit. The wrapper then fetches input words ahead of the core's needs into a small input queue, runs each word through the core, and writes results back behind the core's progress through a result queue. All memory traffic goes through one request/grant master port.

The host polls a status word as a semaphore. Busy rises on a valid start. When the job ends, busy falls and a sticky done flag is set, which the host clears by writing a one to it. A stop bit ends a job early at a word boundary: no new fetches are made, and every word already fetched is still computed and written back before busy falls. A soft-reset bit aborts everything at once but keeps the programmed addresses and count. The core maps each 32-bit word x to rotl(x, 3) + 0x9E3779B9, modulo 2^32.

Top module: `acc_wrapper`

## Requirements
- R1: After reset, STATUS reads 0 and the master port holds mem_req low.
- R2: A start (CTRL bit0) with LEN>0 while idle sets busy (STATUS bit0). When all LEN words have been written back, busy clears and done (STATUS bit1) sets. Destination word k equals rotl(src word k, 3) + 0x9E3779B9.
- R3: Reads go to SRC+4k and writes to DST+4k, in ascending k (byte addresses, 32-bit words). Exactly one word moves on each cycle in which mem_req and mem_gnt are both high, and read data is taken from mem_rdata in that same cycle.
- R4: Once mem_req is high, mem_req, mem_we, mem_addr and mem_wdata stay unchanged until a cycle with mem_gnt high.
- R5: Words read but not yet written back never exceed IN_DEPTH+OUT_DEPTH+1 (9 by default). The read unit makes no fetch while the input queue has no room.
- R6: Done stays set until the host writes STATUS with bit1=1. A job completion in the same cycle as that write leaves done set.
- R7: Stop (CTRL bit1) during a job allows at most one further read after the stop write. Every word already read is still written back before busy clears, and done is then set. Stop while idle has no effect.
- R8: Soft reset (CTRL bit2, which takes priority over the other CTRL bits) clears busy, done and error, and drops mem_req within two cycles. SRC, DST and LEN keep their values.
- R9: A start with LEN=0, or a start while busy, sets error (STATUS bit2) and is otherwise ignored. Error is cleared by writing STATUS with bit2=1.
- R10: Register offsets are 0 CTRL, 1 STATUS, 2 SRC, 3 DST, 4 LEN. Read data appears one cycle after the address. CTRL and unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data for host_addr |
| mem_req | output | 1 | Master port request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; the transfer completes in this cycle |
| mem_rdata | input | 32 | Read data, valid while mem_gnt is high on a read |

## Verification
Two events can fall in the same cycle. The first is hardware completion of a job setting done. The second is a host write-one-to-clear on STATUS. The bench provokes this by writing the clear every cycle throughout a job while also watching the registered status word. The first sample that shows busy low must also show done high, which proves the set won that edge, and a later read must show done cleared. The same bench also starts a second job while one is running, and checks that the error flag rises while the word count of the running job is unchanged.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DW = 32;
  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_SRC    = 3'd2;
  localparam logic [2:0] OFS_DST    = 3'd3;
  localparam logic [2:0] OFS_LEN    = 3'd4;
  localparam int B_START = 0;
  localparam int B_STOP  = 1;
  localparam int B_SRST  = 2;
  localparam int B_BUSY  = 0;
  localparam int B_DONE  = 1;
  localparam int B_ERR   = 2;
endpackage

// File: rtl/acc_fifo.sv
module acc_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage carries no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push && full |-> pop);
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int W = 32,
  parameter int ROT = 3,
  parameter logic [W-1:0] ADD = 32'h9E37_79B9,
  parameter int OUT_DEPTH = 4,
  localparam int CW = $clog2(OUT_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_empty,
  input  logic [W-1:0]  in_data,
  output logic          in_pop,
  input  logic [CW-1:0] out_count,
  output logic          out_push,
  output logic [W-1:0]  out_data,
  output logic          busy
);
  localparam int R = ROT % W;

  logic          s1_v, s2_v;
  logic [W-1:0]  s1_d, s2_d;
  logic [W-1:0]  rot_w;

  generate
    if (R == 0) begin : g_norot
      assign rot_w = in_data;
    end else begin : g_rot
      assign rot_w = {in_data[W-1-R:0], in_data[W-1:W-R]};
    end
  endgenerate

  // take a word only if the result queue has room for everything in flight
  assign in_pop = !in_empty &&
                  ((int'(out_count) + int'(s1_v) + int'(s2_v)) < OUT_DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= in_pop;
      s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    s1_d <= rot_w;
    s2_d <= s1_d + ADD;
  end

  assign out_push = s2_v;
  assign out_data = s2_d;
  assign busy     = s1_v | s2_v;

  // R5
  credit_chk: assert property (@(posedge clk) disable iff (rst) s2_v |-> int'(out_count) < OUT_DEPTH);
endmodule

// File: rtl/acc_regs.sv
module acc_regs
  import acc_pkg::*;
#(
  parameter int AW = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [2:0]       host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic             fin,
  output logic             launch,
  output logic             stop_req,
  output logic             srst,
  output logic [AW-1:0]    src,
  output logic [AW-1:0]    dst,
  output logic [LEN_W-1:0] len
);
  logic busy_q, done_q, err_q;
  logic wr_ctrl, wr_stat, start_w, start_ok, start_bad, stop_w;

  assign wr_ctrl   = host_wr && (host_addr == OFS_CTRL);
  assign wr_stat   = host_wr && (host_addr == OFS_STATUS);
  assign srst      = wr_ctrl && host_wdata[B_SRST];
  assign start_w   = wr_ctrl && host_wdata[B_START] && !srst;
  assign stop_w    = wr_ctrl && host_wdata[B_STOP] && !srst;
  assign start_ok  = start_w && !busy_q && (len != '0);
  assign start_bad = start_w && !start_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      src <= '0;
      dst <= '0;
      len <= '0;
    end else if (host_wr) begin
      case (host_addr)
        OFS_SRC: src <= AW'(host_wdata);
        OFS_DST: dst <= AW'(host_wdata);
        OFS_LEN: len <= LEN_W'(host_wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      launch   <= 1'b0;
      stop_req <= 1'b0;
    end else begin
      launch   <= start_ok;
      stop_req <= stop_w && busy_q;
      if (start_ok)  busy_q <= 1'b1;
      else if (fin)  busy_q <= 1'b0;
      // hardware set wins over a host clear in the same cycle
      if (fin)                                  done_q <= 1'b1;
      else if (start_ok)                        done_q <= 1'b0;
      else if (wr_stat && host_wdata[B_DONE])   done_q <= 1'b0;
      if (start_bad)                            err_q <= 1'b1;
      else if (wr_stat && host_wdata[B_ERR])    err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else begin
      case (host_addr)
        OFS_STATUS: host_rdata <= DW'({err_q, done_q, busy_q});
        OFS_SRC:    host_rdata <= DW'(src);
        OFS_DST:    host_rdata <= DW'(dst);
        OFS_LEN:    host_rdata <= DW'(len);
        default:    host_rdata <= '0;
      endcase
    end
  end

  // R2
  fin_done_chk: assert property (@(posedge clk) disable iff (rst) fin && !srst |=> !busy_q && done_q);
  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done_q && !srst && !start_ok && !(wr_stat && host_wdata[B_DONE]) |=> done_q);
  // R9
  bad_start_chk: assert property (@(posedge clk) disable iff (rst) start_bad && !srst |=> err_q && !launch);
endmodule

// File: rtl/acc_dma.sv
module acc_dma #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LEN_W = 16,
  parameter int IN_DEPTH = 4,
  localparam int ICW = $clog2(IN_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             stop_req,
  input  logic [AW-1:0]    src,
  input  logic [AW-1:0]    dst,
  input  logic [LEN_W-1:0] len,
  input  logic [ICW-1:0]   in_count,
  input  logic             in_empty,
  output logic             in_push,
  output logic [DW-1:0]    in_data,
  input  logic             out_empty,
  input  logic [DW-1:0]    out_data,
  output logic             out_pop,
  input  logic             pipe_busy,
  output logic             fin,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_gnt,
  input  logic [DW-1:0]    mem_rdata
);
  localparam logic [AW-1:0] STRIDE = AW'(DW / 8);

  logic             active, stopping;
  logic             req_q, we_q;
  logic [AW-1:0]    addr_q, rd_ptr, wr_ptr;
  logic [DW-1:0]    wdata_q;
  logic [LEN_W-1:0] rd_iss, len_q;
  logic xfer, slot_free, rd_pend, room, can_wr, can_rd, issue_wr, issue_rd, all_read;

  assign xfer      = req_q & mem_gnt;
  assign slot_free = ~req_q | xfer;
  assign rd_pend   = req_q & ~we_q;
  assign room      = (int'(in_count) + int'(rd_pend)) < IN_DEPTH;
  assign can_wr    = active & ~out_empty;
  assign can_rd    = active & ~stopping & ~stop_req & (rd_iss != len_q) & room;
  // write-behind has the slot first so results never back up behind fetches
  assign issue_wr  = slot_free & can_wr;
  assign issue_rd  = slot_free & ~can_wr & can_rd;
  assign all_read  = (rd_iss == len_q) | stopping;

  assign out_pop = issue_wr;
  assign in_push = xfer & ~we_q;
  assign in_data = mem_rdata;
  assign fin     = active & all_read & ~req_q & in_empty & ~pipe_busy & out_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      stopping <= 1'b0;
      req_q    <= 1'b0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      rd_iss   <= '0;
      len_q    <= '0;
    end else if (launch) begin
      active   <= 1'b1;
      stopping <= 1'b0;
      rd_iss   <= '0;
      rd_ptr   <= src;
      wr_ptr   <= dst;
      len_q    <= len;
    end else begin
      if (fin) active <= 1'b0;
      if (stop_req && active) stopping <= 1'b1;
      if (issue_wr) begin
        req_q   <= 1'b1;
        we_q    <= 1'b1;
        addr_q  <= wr_ptr;
        wr_ptr  <= wr_ptr + STRIDE;
        wdata_q <= out_data;
      end else if (issue_rd) begin
        req_q   <= 1'b1;
        we_q    <= 1'b0;
        addr_q  <= rd_ptr;
        rd_ptr  <= rd_ptr + STRIDE;
        rd_iss  <= rd_iss + 1'b1;
      end else if (xfer) begin
        req_q   <= 1'b0;
      end
    end
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_q && !mem_gnt |=> req_q && $stable(addr_q) && $stable(we_q) && $stable(wdata_q));
  // R7
  stop_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    stopping && !req_q && !launch |=> !(req_q && !we_q));
endmodule

// File: rtl/acc_wrapper.sv
module acc_wrapper
  import acc_pkg::*;
#(
  parameter int AW = 32,
  parameter int LEN_W = 16,
  parameter int IN_DEPTH = 4,
  parameter int OUT_DEPTH = 4,
  parameter int ROT = 3,
  parameter logic [31:0] ADD = 32'h9E37_79B9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic [2:0]    host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata
);
  localparam int ICW = $clog2(IN_DEPTH + 1);
  localparam int OCW = $clog2(OUT_DEPTH + 1);

  logic             fin, launch, stop_req, srst, dp_rst;
  logic [AW-1:0]    src, dst;
  logic [LEN_W-1:0] len;
  logic             in_push, in_pop, in_empty, in_full;
  logic [DW-1:0]    in_din, in_dout;
  logic [ICW-1:0]   in_count;
  logic             out_push, out_pop, out_empty, out_full;
  logic [DW-1:0]    out_din, out_dout;
  logic [OCW-1:0]   out_count;
  logic             pipe_busy;

  assign dp_rst = rst | srst;

  acc_regs #(.AW(AW), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .fin(fin),
    .launch(launch), .stop_req(stop_req), .srst(srst),
    .src(src), .dst(dst), .len(len)
  );

  acc_fifo #(.W(DW), .DEPTH(IN_DEPTH)) u_inq (
    .clk(clk), .rst(dp_rst), .push(in_push), .din(in_din), .pop(in_pop),
    .dout(in_dout), .count(in_count), .empty(in_empty), .full(in_full)
  );

  acc_core #(.W(DW), .ROT(ROT), .ADD(ADD), .OUT_DEPTH(OUT_DEPTH)) u_core (
    .clk(clk), .rst(dp_rst), .in_empty(in_empty), .in_data(in_dout),
    .in_pop(in_pop), .out_count(out_count), .out_push(out_push),
    .out_data(out_din), .busy(pipe_busy)
  );

  acc_fifo #(.W(DW), .DEPTH(OUT_DEPTH)) u_outq (
    .clk(clk), .rst(dp_rst), .push(out_push), .din(out_din), .pop(out_pop),
    .dout(out_dout), .count(out_count), .empty(out_empty), .full(out_full)
  );

  acc_dma #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .IN_DEPTH(IN_DEPTH)) u_dma (
    .clk(clk), .rst(dp_rst), .launch(launch), .stop_req(stop_req),
    .src(src), .dst(dst), .len(len), .in_count(in_count), .in_empty(in_empty),
    .in_push(in_push), .in_data(in_din), .out_empty(out_empty),
    .out_data(out_dout), .out_pop(out_pop), .pipe_busy(pipe_busy), .fin(fin),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !mem_req);
endmodule

// File: tb/sim_acc_wrapper.sv
module sim_acc_wrapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [31:0] host_wdata = 32'd0;
  logic [31:0] host_rdata;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int fails = 0;
  logic [31:0] mem [1024];
  logic        gnt_always = 1'b0;
  logic        proto_skip = 1'b0;
  logic [31:0] job_src, job_dst;
  int rd_cnt, wr_cnt, max_out, proto_viol;
  logic        p_req, p_gnt, p_we;
  logic [31:0] p_addr, p_wdata;

  always #4 clk = ~clk;

  acc_wrapper u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[11:2]];

  function automatic logic [31:0] xf(input logic [31:0] x);
    return {x[28:0], x[31:29]} + 32'h9E37_79B9;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    mem_gnt = 1'b0;
    forever begin
      @(posedge clk);
      #1 mem_gnt = gnt_always ? 1'b1 : (($urandom % 100) < 60);
    end
  end

  // memory side monitor, sampled at the falling edge
  initial begin
    p_req = 1'b0; p_gnt = 1'b0; p_we = 1'b0; p_addr = '0; p_wdata = '0;
    forever begin
      @(negedge clk);
      if (!rst && !proto_skip && p_req && !p_gnt) begin
        if (!(mem_req && mem_we == p_we && mem_addr == p_addr && mem_wdata == p_wdata))
          proto_viol++;
      end
      if (!rst && mem_req && mem_gnt) begin
        if (!mem_we) begin
          chk(mem_addr == job_src + 32'(rd_cnt) * 4, "R3 read address", mem_addr,
              job_src + 32'(rd_cnt) * 4);
          rd_cnt++;
        end else begin
          chk(mem_addr == job_dst + 32'(wr_cnt) * 4, "R3 write address", mem_addr,
              job_dst + 32'(wr_cnt) * 4);
          chk(mem_wdata == xf(mem[(job_src >> 2) + 32'(wr_cnt)]), "R2 result word", mem_wdata,
              xf(mem[(job_src >> 2) + 32'(wr_cnt)]));
          mem[mem_addr[11:2]] = mem_wdata;
          wr_cnt++;
        end
        if (rd_cnt - wr_cnt > max_out) max_out = rd_cnt - wr_cnt;
      end
      p_req = mem_req; p_gnt = mem_gnt; p_we = mem_we; p_addr = mem_addr; p_wdata = mem_wdata;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic setup_job(input logic [31:0] s, input logic [31:0] d, input int n);
    job_src = s; job_dst = d;
    rd_cnt = 0; wr_cnt = 0; max_out = 0; proto_viol = 0;
    wr(3'd2, s);
    wr(3'd3, d);
    wr(3'd4, 32'(n));
  endtask

  task automatic wait_idle(output logic [31:0] st);
    st = 32'h1;
    for (int i = 0; i < 5000 && st[0]; i++) rd(3'd1, st);
  endtask

  task automatic job_checks(input int n, input logic [31:0] st, input logic [31:0] exp_st);
    chk(wr_cnt == n, "R2 words written", 32'(wr_cnt), 32'(n));
    chk(st[2:0] == exp_st[2:0], "R2 status after job", st, exp_st);
    chk(proto_viol == 0, "R4 request held until grant", 32'(proto_viol), 32'd0);
    chk(max_out <= 9, "R5 outstanding words bound", 32'(max_out), 32'd9);
  endtask

  initial begin
    logic [31:0] st, v;
    int unsigned seed;
    seed = $urandom(32'd2024);
    job_src = 0; job_dst = 0; rd_cnt = 0; wr_cnt = 0; max_out = 0; proto_viol = 0;
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd(3'd1, st);
    chk(st == 32'd0, "R1 status after reset", st, 32'd0);
    chk(mem_req == 1'b0, "R1 no request after reset", 32'(mem_req), 32'd0);

    // R10 register map and readback
    wr(3'd2, 32'h0000_0040); wr(3'd3, 32'h0000_0900); wr(3'd4, 32'd5);
    rd(3'd2, v); chk(v == 32'h40, "R10 SRC readback", v, 32'h40);
    rd(3'd3, v); chk(v == 32'h900, "R10 DST readback", v, 32'h900);
    rd(3'd4, v); chk(v == 32'd5, "R10 LEN readback", v, 32'd5);
    rd(3'd0, v); chk(v == 32'd0, "R10 CTRL reads zero", v, 32'd0);
    rd(3'd7, v); chk(v == 32'd0, "R10 unused offset reads zero", v, 32'd0);

    // R7 stop while idle has no effect
    wr(3'd0, 32'h2);
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0, "R7 idle stop no request", 32'(mem_req), 32'd0);
    rd(3'd1, st); chk(st == 32'd0, "R7 idle stop status", st, 32'd0);

    // R2 R3 basic job with random grants
    setup_job(32'h0000_0100, 32'h0000_0A00, 12);
    wr(3'd0, 32'h1);
    wait_idle(st);
    job_checks(12, st, 32'h2);

    // R6 done sticky, then cleared by write-one
    repeat (20) @(negedge clk);
    rd(3'd1, st); chk(st == 32'h2, "R6 done stays set", st, 32'h2);
    wr(3'd1, 32'h2);
    rd(3'd1, st); chk(st == 32'h0, "R6 done cleared by host", st, 32'h0);

    // R9 start with zero length
    wr(3'd4, 32'd0);
    wr(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0, "R9 zero length no request", 32'(mem_req), 32'd0);
    rd(3'd1, st); chk(st == 32'h4, "R9 error on zero length", st, 32'h4);
    wr(3'd1, 32'h4);
    rd(3'd1, st); chk(st == 32'h0, "R9 error cleared", st, 32'h0);

    // R9 start while busy is ignored apart from error
    setup_job(32'h0000_0200, 32'h0000_0B00, 20);
    wr(3'd0, 32'h1);
    wr(3'd0, 32'h1);
    wait_idle(st);
    job_checks(20, st, 32'h6);
    wr(3'd1, 32'h6);
    rd(3'd1, st); chk(st == 32'h0, "R9 flags cleared", st, 32'h0);

    // R7 stop mid job, grants always given
    gnt_always = 1'b1;
    setup_job(32'h0000_0000, 32'h0000_0C00, 60);
    wr(3'd0, 32'h1);
    repeat (15) @(negedge clk);
    begin
      int snap;
      @(negedge clk);
      host_wr = 1'b1; host_addr = 3'd0; host_wdata = 32'h2;
      @(posedge clk);
      #1 snap = rd_cnt;
      @(negedge clk);
      host_wr = 1'b0;
      wait_idle(st);
      chk(rd_cnt - snap <= 1, "R7 reads after stop", 32'(rd_cnt - snap), 32'd1);
      chk(rd_cnt < 60, "R7 job cut short", 32'(rd_cnt), 32'd60);
      job_checks(rd_cnt, st, 32'h2);
    end
    wr(3'd1, 32'h2);
    gnt_always = 1'b0;

    // R8 soft reset mid job
    setup_job(32'h0000_0180, 32'h0000_0D00, 50);
    wr(3'd0, 32'h1);
    repeat (12) @(negedge clk);
    proto_skip = 1'b1;
    wr(3'd0, 32'h7);
    repeat (2) @(negedge clk);
    chk(mem_req == 1'b0, "R8 request dropped", 32'(mem_req), 32'd0);
    rd(3'd1, st); chk(st == 32'h0, "R8 status cleared", st, 32'h0);
    proto_skip = 1'b0;
    rd(3'd2, v); chk(v == 32'h180, "R8 SRC kept", v, 32'h180);
    rd(3'd3, v); chk(v == 32'hD00, "R8 DST kept", v, 32'hD00);
    rd(3'd4, v); chk(v == 32'd50, "R8 LEN kept", v, 32'd50);

    // R6 completion and host clear in the same cycle
    setup_job(32'h0000_0240, 32'h0000_0E00, 8);
    wr(3'd0, 32'h1);
    begin
      bit seen = 1'b0;
      logic [31:0] sv = '0;
      for (int i = 0; i < 3000 && !seen; i++) begin
        @(negedge clk);
        if (i >= 2 && host_rdata[0] == 1'b0) begin
          seen = 1'b1; sv = host_rdata;
          host_wr = 1'b0;
        end else begin
          host_wr = 1'b1; host_addr = 3'd1; host_wdata = 32'h2;
        end
      end
      host_wr = 1'b0;
      chk(sv[1] == 1'b1, "R6 set wins over clear", sv, 32'h2);
      rd(3'd1, st); chk(st == 32'h0, "R6 cleared afterwards", st, 32'h0);
      chk(wr_cnt == 8, "R2 words in race job", 32'(wr_cnt), 32'd8);
    end

    // R2 R3 R5 random jobs, including single-word corner
    for (int j = 0; j < 8; j++) begin
      int n;
      logic [31:0] s, d;
      n = (j == 0) ? 1 : 1 + int'($urandom % 24);
      s = 32'(4 * ($urandom % 200));
      d = 32'h800 + 32'(4 * ($urandom % 200));
      gnt_always = (j % 3 == 2);
      setup_job(s, d, n);
      wr(3'd0, 32'h1);
      wait_idle(st);
      job_checks(n, st, 32'h2);
      wr(3'd1, 32'h2);
    end
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end
endmodule